// File: doc/BRIEF.md
# Timer Channel Control and Status Register

This block is the 16-bit control and status word of a single down-counting timer channel. Software writes it to choose the count clock prescale, to choose which edge of an external clock is counted, and to enable the underflow interrupt. The block drives those selections straight out to the counter logic, which lies outside this block.

The counter logic signals an underflow with a one-cycle event pulse. The block then sets a sticky underflow flag. The flag stays at 1 until software writes a 0 to its bit. Writing a 1 to a flag bit leaves the flag as it was. If an event and a clearing write land in the same cycle, the event wins.

A build-time parameter adds an input-capture variant. That variant has a sticky capture flag, set by a capture event pulse, and two read/write capture control bits. The interrupt output is a level, and the capture flag feeds it only when both capture control bits are 1. A read strobe loads the register view into a read-data register, which holds its value until the next strobe.

Top module: `timer_chan_csr`

## Requirements
- R1: After reset, every field, the read data, the selection outputs and `irq` are 0.
- R2: Bits 15:10 always read as 0, whatever value is written to them.
- R3: A write loads bits 2:0 into the prescale select and bits 4:3 into the edge select. Both read back in place and are driven on `clkSelect` and `edgeSelect` from the cycle after the write.
- R4: Bit 5 is the underflow interrupt enable and reads back in place. `irq` is 1 while bit 5 and the underflow flag (bit 8) are both 1, counting only those two bits.
- R5: Bit 8, the underflow flag, is set on the cycle after an `underflowEvt` pulse. A write with bit 8 = 0 clears it, and a write with bit 8 = 1 leaves it unchanged.
- R6: When a flag's set event and a write of 0 to that flag occur in the same cycle, the flag ends up at 1.
- R7: With `HAS_CAPTURE` = 1, bit 9 is the capture flag. A `captureEvt` pulse sets it, a write of 0 to bit 9 clears it, and a write of 1 to bit 9 leaves it unchanged.
- R8: With `HAS_CAPTURE` = 1, bits 7:6 are read/write, read back in place and are driven on `captureCtl`. `irq` is also 1 while the capture flag is 1 and bits 7:6 equal 2'b11.
- R9: With `HAS_CAPTURE` = 0, bits 9, 7 and 6 read as 0, `captureCtl` stays 0, and `captureEvt` has no effect on the read data or on `irq`.
- R10: `rdData` takes the register value present in the cycle in which `rdEn` is high, and shows it from the next cycle on. Without `rdEn`, `rdData` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrData | input | 16 | Write value |
| rdEn | input | 1 | Read strobe |
| rdData | output | 16 | Registered read value |
| underflowEvt | input | 1 | Counter underflow pulse |
| captureEvt | input | 1 | Input capture pulse |
| clkSelect | output | 3 | Prescale select to the counter |
| edgeSelect | output | 2 | External clock edge select |
| captureCtl | output | 2 | Capture control bits |
| irq | output | 1 | Interrupt request level |

## Verification
On every cycle, the assertions check these behaviours: a flag rises after its event, a flag falls only after a write of 0 to its bit, a same-cycle event beats a clear, selection outputs follow the written fields, and `rdData` stays stable without a read strobe. The bench scenarios are needed to show that reserved bits read as zero and that the interrupt level follows each combination of enables and flags. They also show the capture gating on 2'b11, and that the variant without capture ignores capture events and masks its bits.

// File: rtl/timer_csr_pkg.sv
package timer_csr_pkg;
  localparam int REG_W      = 16;
  localparam int PRESC_LSB  = 0;
  localparam int PRESC_W    = 3;
  localparam int EDGE_LSB   = 3;
  localparam int EDGE_W     = 2;
  localparam int UNIE_BIT   = 5;
  localparam int CAPCTL_LSB = 6;
  localparam int CAPCTL_W   = 2;
  localparam int UNF_BIT    = 8;
  localparam int CAPF_BIT   = 9;

  typedef struct packed {
    logic loadCfg;
    logic clrUnf;
    logic clrCap;
    logic latchRead;
  } csrStrobe_t;
endpackage

// File: rtl/timer_csr_ctrl.sv
module timer_csr_ctrl
  import timer_csr_pkg::*;
(
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdEn,
  output csrStrobe_t       strobe
);
  // Flag bits clear only on a written 0; a written 1 is a no-op.
  always_comb begin
    strobe.loadCfg   = wrEn;
    strobe.clrUnf    = wrEn && !wrData[UNF_BIT];
    strobe.clrCap    = wrEn && !wrData[CAPF_BIT];
    strobe.latchRead = rdEn;
  end

  logic unusedWrBits;
  assign unusedWrBits = ^{wrData[REG_W-1:CAPF_BIT+1], wrData[UNF_BIT-1:0]};
endmodule

// File: rtl/timer_csr_dp.sv
module timer_csr_dp
  import timer_csr_pkg::*;
#(
  parameter bit HAS_CAPTURE = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  csrStrobe_t          strobe,
  input  logic [REG_W-1:0]    wrData,
  input  logic                underflowEvt,
  input  logic                captureEvt,
  output logic [REG_W-1:0]    rdData,
  output logic [PRESC_W-1:0]  clkSelect,
  output logic [EDGE_W-1:0]   edgeSelect,
  output logic [CAPCTL_W-1:0] captureCtl,
  output logic                irq
);
  logic [PRESC_W-1:0]  prescReg;
  logic [EDGE_W-1:0]   edgeReg;
  logic                unieReg;
  logic                unfReg;
  logic [CAPCTL_W-1:0] capCtlReg;
  logic                capFlagReg;
  logic [REG_W-1:0]    regView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescReg <= '0;
      edgeReg  <= '0;
      unieReg  <= 1'b0;
    end else if (strobe.loadCfg) begin
      prescReg <= wrData[PRESC_LSB +: PRESC_W];
      edgeReg  <= wrData[EDGE_LSB +: EDGE_W];
      unieReg  <= wrData[UNIE_BIT];
    end
  end

  // Event set has priority over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rstN) unfReg <= 1'b0;
    else       unfReg <= underflowEvt | (unfReg & ~strobe.clrUnf);
  end

  generate
    if (HAS_CAPTURE) begin : g_capture
      always_ff @(posedge clk) begin
        if (!rstN) begin
          capCtlReg  <= '0;
          capFlagReg <= 1'b0;
        end else begin
          if (strobe.loadCfg) capCtlReg <= wrData[CAPCTL_LSB +: CAPCTL_W];
          capFlagReg <= captureEvt | (capFlagReg & ~strobe.clrCap);
        end
      end

      assert_cap_set_R7: assert property (@(posedge clk) disable iff (!rstN)
        captureEvt |=> capFlagReg);
      assert_cap_clear_only_by_write_R7: assert property (@(posedge clk) disable iff (!rstN)
        $fell(capFlagReg) |-> $past(strobe.loadCfg && !wrData[CAPF_BIT]));
    end else begin : g_plain
      assign capCtlReg  = '0;
      assign capFlagReg = 1'b0;
      logic unusedCapInputs;
      assign unusedCapInputs = captureEvt ^ strobe.clrCap;
    end
  endgenerate

  always_comb begin
    regView = '0;
    regView[PRESC_LSB +: PRESC_W]   = prescReg;
    regView[EDGE_LSB +: EDGE_W]     = edgeReg;
    regView[UNIE_BIT]               = unieReg;
    regView[CAPCTL_LSB +: CAPCTL_W] = capCtlReg;
    regView[UNF_BIT]                = unfReg;
    regView[CAPF_BIT]               = capFlagReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 rdData <= '0;
    else if (strobe.latchRead) rdData <= regView;
  end

  assign clkSelect  = prescReg;
  assign edgeSelect = edgeReg;
  assign captureCtl = capCtlReg;
  assign irq = (unfReg & unieReg) | (capFlagReg & (&capCtlReg));

  logic unusedWrHigh;
  assign unusedWrHigh = ^wrData[REG_W-1:CAPCTL_LSB+CAPCTL_W];

  assert_unf_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    underflowEvt |=> unfReg);
  assert_unf_clear_only_by_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(unfReg) |-> $past(strobe.loadCfg && !wrData[UNF_BIT]));
  assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (underflowEvt && strobe.clrUnf) |=> rdData[UNF_BIT] == $past(rdData[UNF_BIT]) || unfReg);
  assert_sel_follows_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCfg |=> (clkSelect == $past(wrData[PRESC_LSB +: PRESC_W]))
                     && (edgeSelect == $past(wrData[EDGE_LSB +: EDGE_W])));
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchRead |=> $stable(rdData));
endmodule

// File: rtl/timer_chan_csr.sv
module timer_chan_csr
  import timer_csr_pkg::*;
#(
  parameter bit HAS_CAPTURE = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [REG_W-1:0]    wrData,
  input  logic                rdEn,
  output logic [REG_W-1:0]    rdData,
  input  logic                underflowEvt,
  input  logic                captureEvt,
  output logic [PRESC_W-1:0]  clkSelect,
  output logic [EDGE_W-1:0]   edgeSelect,
  output logic [CAPCTL_W-1:0] captureCtl,
  output logic                irq
);
  csrStrobe_t strobe;

  timer_csr_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdEn   (rdEn),
    .strobe (strobe)
  );

  timer_csr_dp #(.HAS_CAPTURE(HAS_CAPTURE)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (wrData),
    .underflowEvt (underflowEvt),
    .captureEvt   (captureEvt),
    .rdData       (rdData),
    .clkSelect    (clkSelect),
    .edgeSelect   (edgeSelect),
    .captureCtl   (captureCtl),
    .irq          (irq)
  );
endmodule

// File: tb/timer_chan_csr_test.sv
`timescale 1ns/1ps
module timer_chan_csr_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic rdEn = 1'b0;
  logic underflowEvt = 1'b0;
  logic captureEvt = 1'b0;
  logic [15:0] rdData, rdDataNc;
  logic [2:0] clkSelect, clkSelectNc;
  logic [1:0] edgeSelect, edgeSelectNc, captureCtl, captureCtlNc;
  logic irq, irqNc;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  timer_chan_csr #(.HAS_CAPTURE(1'b1)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .underflowEvt(underflowEvt), .captureEvt(captureEvt),
    .clkSelect(clkSelect), .edgeSelect(edgeSelect), .captureCtl(captureCtl), .irq(irq));

  timer_chan_csr #(.HAS_CAPTURE(1'b0)) uutNc (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdDataNc), .underflowEvt(underflowEvt), .captureEvt(captureEvt),
    .clkSelect(clkSelectNc), .edgeSelect(edgeSelectNc), .captureCtl(captureCtlNc), .irq(irqNc));

  // {wr, wrData[15:0], underflow, capture, expected read[15:0], expected irq}
  localparam int NVEC = 13;
  localparam logic [35:0] VECS [NVEC] = '{
    {1'b1, 16'h0007, 1'b0, 1'b0, 16'h0007, 1'b0},  // R3
    {1'b1, 16'hFC1A, 1'b0, 1'b0, 16'h001A, 1'b0},  // R2 R3
    {1'b0, 16'h0000, 1'b1, 1'b0, 16'h011A, 1'b0},  // R5 R4
    {1'b1, 16'h013A, 1'b0, 1'b0, 16'h013A, 1'b1},  // R4 R5
    {1'b1, 16'h0020, 1'b0, 1'b0, 16'h0020, 1'b0},  // R5
    {1'b1, 16'h0000, 1'b1, 1'b0, 16'h0100, 1'b0},  // R6
    {1'b1, 16'h00E0, 1'b0, 1'b0, 16'h00E0, 1'b0},  // R8
    {1'b0, 16'h0000, 1'b0, 1'b1, 16'h02E0, 1'b1},  // R7 R8
    {1'b1, 16'h02A0, 1'b0, 1'b0, 16'h02A0, 1'b0},  // R8
    {1'b1, 16'h00C0, 1'b0, 1'b1, 16'h02C0, 1'b1},  // R6 R7
    {1'b1, 16'h00C0, 1'b0, 1'b0, 16'h00C0, 1'b0},  // R7
    {1'b0, 16'h0000, 1'b1, 1'b1, 16'h03C0, 1'b1},  // R5 R7
    {1'b1, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0}   // R5 R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic wr, input logic [15:0] wd, input logic uf, input logic cp,
                       input logic rd);
    wrEn = wr; wrData = wd; underflowEvt = uf; captureEvt = cp; rdEn = rd;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; underflowEvt = 1'b0; captureEvt = 1'b0; rdEn = 1'b0;
  endtask

  initial begin
    #(5.0 * 5000);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 rdData", rdData, 0);
    check("R1 irq", irq, 0);
    check("R1 selects", {clkSelect, edgeSelect, captureCtl}, 0);
    cycle(1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    check("R1 read after reset", rdData, 0);

    for (int i = 0; i < NVEC; i++) begin
      cycle(VECS[i][35], VECS[i][34:19], VECS[i][18], VECS[i][17], 1'b0);
      cycle(1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
      check($sformatf("R2-R8 vec%0d rdData", i), rdData, VECS[i][16:1]);
      check($sformatf("R4 R8 vec%0d irq", i), irq, VECS[i][0]);
    end

    // R3: selection outputs follow the fields
    cycle(1'b1, 16'h0015, 1'b0, 1'b0, 1'b0);
    check("R3 clkSelect", clkSelect, 3'd5);
    check("R3 edgeSelect", edgeSelect, 2'd2);
    check("R8 captureCtl zero", captureCtl, 2'd0);
    cycle(1'b1, 16'h00C0, 1'b0, 1'b0, 1'b0);
    check("R8 captureCtl", captureCtl, 2'd3);

    // R10: read latency and hold
    cycle(1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    check("R10 latched", rdData, 16'h00C0);
    cycle(1'b1, 16'h0007, 1'b0, 1'b0, 1'b0);
    check("R10 hold without rdEn", rdData, 16'h00C0);
    cycle(1'b1, 16'h0003, 1'b0, 1'b0, 1'b1);
    check("R10 same-cycle write returns old value", rdData, 16'h0007);
    cycle(1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    check("R10 new value next read", rdData, 16'h0003);

    // R9: variant without capture
    cycle(1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0);
    cycle(1'b0, 16'h0, 1'b0, 1'b1, 1'b0);
    cycle(1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    check("R9 masked bits", rdDataNc, 16'h003F);
    check("R9 irq ignores capture", irqNc, 1'b0);
    check("R9 captureCtl", captureCtlNc, 2'd0);
    cycle(1'b0, 16'h0, 1'b1, 1'b1, 1'b0);
    cycle(1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    check("R9 underflow still works", rdDataNc, 16'h013F);
    check("R9 irq from underflow", irqNc, 1'b1);
    check("R7 capture variant flag", rdData, 16'h03FF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule